// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit timer channels behind a single word-addressed register port. Every channel has its own power-of-two clock divider, a counter that runs up or down, and a choice of two spans: the full 16-bit range, or zero up to a programmed limit. Three compare values are checked against the count. Wrap and compare events are latched into a per-channel status register, and each channel drives a level interrupt when any latched event is also enabled in its mask.

Software sets up a channel in a fixed order: divider, limit, compare values and interrupt mask first, then the control register with the stop bit cleared. Reading the status register consumes the latched events, which acknowledges the interrupt. The channel count, the counter width, the number of compare values and the divider field width are all parameters. The address map follows from them: registers of one kind for all channels sit side by side, one word apart, and each kind is a group of channel-count words.

Top module: `tri_timer`

## Requirements
- R1: After reset, every channel's control register reads 0x21 (bit 0 stop set), and its count, divider control, status and interrupt output are all 0.
- R2: Divider control bit 0 enables division. Bits 4:1 hold N, and with division enabled the count advances once every 2^(N+1) clocks. The divider phase restarts when divider control is written, so the first advance falls 2^(N+1) clocks after that write. With division disabled the count advances every clock.
- R3: While control bit 0 (stop) is 1 the count holds its value.
- R4: Counting up, the count wraps from its top value to 0. The top value is the limit register when control bit 1 (limit mode) is set, and 0xFFFF otherwise. A wrap in limit mode sets status bit 0. A wrap in full-range mode sets status bit 4.
- R5: With control bit 2 (down) set, a count of 0 reloads the top value on the next advance and sets the same wrap status bit as counting up. Any other count decrements by one.
- R6: Writing control with bit 4 set clears the count to 0. Bit 4 is not stored and reads back as 0.
- R7: Status bit 1+i is set when an advance brings the count to compare value i (i = 0..2), and only while control bit 3 (compare enable) is 1. A compare value above the current top value never sets its bit.
- R8: A read of the status register returns its contents and clears it. An event latched in the same cycle survives the clear. Writes to status have no effect.
- R9: A channel's interrupt is high exactly when some status bit and the same bit of its 6-bit interrupt mask are both 1.
- R10: Register kind k of channel c sits at byte offset 12k + 4c. The kinds, in order, are: divider control, control, count (read-only), limit, compare 0, compare 1, compare 2, status, interrupt mask, event control (3 bits stored), event count (reads 0). Unaligned or unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while a read is presented |
| irq | output | 3 | Per-channel level interrupt |

## Verification
The embedded assertions check on every cycle that the count holds when no advance is due, steps by exactly one, or wraps to the right value in each direction. They also check that a clearing write zeroes it, that the divider never issues two ticks back to back, that compare bits cannot rise while compare enable is off, and that an event arriving with a status read-clear survives the clear. The address interleave, the divider period and its restart phase, the exact wrap points in both modes, the rule that an out-of-range compare value never fires, and the acknowledge effect of a status read on the interrupt can only be shown by the bench's directed scenarios, through the register port.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // control register field positions (bit 4 is a command, never stored)
   localparam int CTL_W    = 6;
   localparam int CTL_STOP = 0;
   localparam int CTL_LIM  = 1;
   localparam int CTL_DOWN = 2;
   localparam int CTL_CMP  = 3;
   localparam int CTL_CLR  = 4;
   localparam logic [CTL_W-1:0] CTL_RST_VAL = 6'h21;

   // register kinds are laid out in this order; compare kinds follow K_LIM
   localparam int K_CLK  = 0;
   localparam int K_CTRL = 1;
   localparam int K_CNT  = 2;
   localparam int K_LIM  = 3;
   localparam int K_CMP0 = 4;

   function automatic int num_kinds(input int n_cmp);
      return n_cmp + 8;
   endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int PS_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic            ps_en,
   input  logic [PS_W-1:0] ps_sel,
   output logic            tick
);
   localparam int DIV_W = 2 ** PS_W;
   localparam int SH_W  = PS_W + 1;

   if (PS_W < 1 || PS_W > 5) begin : g_bad_psw
      $error("tmr_prescale: PS_W out of range");
   end

   logic [DIV_W-1:0] phase_q;
   logic [DIV_W-1:0] mask;
   logic [SH_W-1:0]  shamt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_q <= '0;
      else if (restart) phase_q <= '0;
      else              phase_q <= phase_q + 1'b1;
   end

   always_comb begin
      shamt = {1'b0, ps_sel} + SH_W'(1);
      mask  = (DIV_W'(1) << shamt) - DIV_W'(1);
      tick  = ps_en ? ((phase_q & mask) == mask) : 1'b1;
   end

   // R2: the shortest divided period is two clocks
   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ps_en && tick) |=> (!tick || !ps_en));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             clr,
   input  logic             down,
   input  logic [CNT_W-1:0] top,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             step,
   output logic             wrap
);
   logic at_end;

   always_comb begin
      at_end  = down ? (cnt_q == '0) : (cnt_q >= top);
      if (down) cnt_nxt = at_end ? top : cnt_q - 1'b1;
      else      cnt_nxt = at_end ? '0  : cnt_q + 1'b1;
      step    = adv && !clr;
      wrap    = step && at_end;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (adv) cnt_q <= cnt_nxt;
   end

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(cnt_q));
   p_up_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr && !down && cnt_q < top) |=> cnt_q == $past(cnt_q) + 1'b1);
   p_up_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr && !down && cnt_q >= top) |=> cnt_q == '0);
   p_down_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr && down && cnt_q == '0) |=> cnt_q == $past(top));
   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt_q == '0);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int N_CMP  = 3,
   parameter int PS_W   = 4,
   parameter int DATA_W = 32,
   parameter int KIND_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [KIND_W-1:0] kind,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   localparam int CLK_W  = PS_W + 2;
   localparam int ST_W   = N_CMP + 3;
   localparam int ST_OVF = N_CMP + 1;
   localparam int EVC_W  = 3;
   localparam logic [KIND_W-1:0] KS_CLK  = KIND_W'(K_CLK);
   localparam logic [KIND_W-1:0] KS_CTRL = KIND_W'(K_CTRL);
   localparam logic [KIND_W-1:0] KS_CNT  = KIND_W'(K_CNT);
   localparam logic [KIND_W-1:0] KS_LIM  = KIND_W'(K_LIM);
   localparam logic [KIND_W-1:0] KS_ST   = KIND_W'(K_CMP0 + N_CMP);
   localparam logic [KIND_W-1:0] KS_IEN  = KIND_W'(K_CMP0 + N_CMP + 1);
   localparam logic [KIND_W-1:0] KS_EVC  = KIND_W'(K_CMP0 + N_CMP + 2);

   if (CNT_W < 2 || N_CMP < 1 || DATA_W < CNT_W || DATA_W < CLK_W) begin : g_bad_par
      $error("tmr_channel: parameter combination not supported");
   end

   logic [CLK_W-1:0] clk_q;
   logic [CTL_W-1:0] ctrl_q;
   logic [CNT_W-1:0] lim_q;
   logic [ST_W-1:0]  st_q, ien_q, set_v;
   logic [EVC_W-1:0] evc_q;
   logic [N_CMP-1:0][CNT_W-1:0] cmp_v;
   logic [N_CMP-1:0] cmp_hit;
   logic tick, restart, clr, rd_clr, step, wrap;
   logic [CNT_W-1:0] top, cnt_q, cnt_nxt;

   assign restart = wr_en && kind == KS_CLK;
   assign clr     = wr_en && kind == KS_CTRL && wdata[CTL_CLR];
   assign rd_clr  = rd_en && kind == KS_ST;
   assign top     = ctrl_q[CTL_LIM] ? lim_q : '1;

   tmr_prescale #(.PS_W(PS_W)) u_ps (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .ps_en(clk_q[0]), .ps_sel(clk_q[PS_W:1]), .tick(tick)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .adv(tick && !ctrl_q[CTL_STOP]), .clr(clr),
      .down(ctrl_q[CTL_DOWN]), .top(top), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
      .step(step), .wrap(wrap)
   );

   for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
      localparam logic [KIND_W-1:0] KS_ME = KIND_W'(K_CMP0 + i);
      logic [CNT_W-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       val_q <= '0;
         else if (wr_en && kind == KS_ME)  val_q <= wdata[CNT_W-1:0];
      end
      assign cmp_v[i]   = val_q;
      assign cmp_hit[i] = step && ctrl_q[CTL_CMP] && (cnt_nxt == val_q) && (val_q <= top);
   end

   assign set_v = {1'b0, wrap && !ctrl_q[CTL_LIM], cmp_hit, wrap && ctrl_q[CTL_LIM]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q  <= '0;
         ctrl_q <= CTL_RST_VAL;
         lim_q  <= '0;
         ien_q  <= '0;
         evc_q  <= '0;
         st_q   <= '0;
      end else begin
         if (wr_en) begin
            case (kind)
               KS_CLK:  clk_q  <= wdata[CLK_W-1:0];
               KS_CTRL: ctrl_q <= wdata[CTL_W-1:0] & ~(CTL_W'(1) << CTL_CLR);
               KS_LIM:  lim_q  <= wdata[CNT_W-1:0];
               KS_IEN:  ien_q  <= wdata[ST_W-1:0];
               KS_EVC:  evc_q  <= wdata[EVC_W-1:0];
               default: ;
            endcase
         end
         st_q <= (rd_clr ? '0 : st_q) | set_v;
      end
   end

   always_comb begin
      rdata = '0;
      case (kind)
         KS_CLK:  rdata[CLK_W-1:0] = clk_q;
         KS_CTRL: rdata[CTL_W-1:0] = ctrl_q;
         KS_CNT:  rdata[CNT_W-1:0] = cnt_q;
         KS_LIM:  rdata[CNT_W-1:0] = lim_q;
         KS_ST:   rdata[ST_W-1:0]  = st_q;
         KS_IEN:  rdata[ST_W-1:0]  = ien_q;
         KS_EVC:  rdata[EVC_W-1:0] = evc_q;
         default: ;
      endcase
      for (int i = 0; i < N_CMP; i++)
         if (kind == KIND_W'(K_CMP0 + i)) rdata[CNT_W-1:0] = cmp_v[i];
   end

   assign irq = |(st_q & ien_q);

   p_cmp_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[CTL_CMP] |=> (st_q[N_CMP:1] & ~$past(st_q[N_CMP:1])) == '0);
   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_v) |=> (st_q & $past(set_v)) == $past(set_v));
   p_rd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && set_v == '0) |=> st_q == '0);
   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q & ien_q) == '0) |-> !irq);
   p_no_ovf_in_lim_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[CTL_LIM] && !st_q[ST_OVF] && !rd_clr) |=> !st_q[ST_OVF]);
endmodule

// File: rtl/tri_timer.sv
module tri_timer
   import tmr_pkg::*;
#(
   parameter int N_CH   = 3,
   parameter int CNT_W  = 16,
   parameter int N_CMP  = 3,
   parameter int PS_W   = 4,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [N_CH-1:0]   irq
);
   localparam int NUM_KIND = num_kinds(N_CMP);
   localparam int KIND_W   = $clog2(NUM_KIND);
   localparam int WIDX_W   = ADDR_W - 2;

   if (N_CH < 1 || KIND_W > WIDX_W || NUM_KIND * N_CH * 4 > 2 ** ADDR_W) begin : g_bad_map
      $error("tri_timer: address width too small for the register map");
   end

   logic [WIDX_W-1:0] widx, kind_i, ch_i;
   logic              hit, rd_go;
   logic [N_CH-1:0]   sel;
   logic [DATA_W-1:0] ch_rdata [N_CH];

   assign widx   = bus_addr[ADDR_W-1:2];
   assign kind_i = widx / WIDX_W'(N_CH);
   assign ch_i   = widx % WIDX_W'(N_CH);
   assign hit    = bus_en && (bus_addr[1:0] == 2'b00) && (kind_i < WIDX_W'(NUM_KIND));
   assign rd_go  = hit && !bus_we;

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      assign sel[g] = hit && (ch_i == WIDX_W'(g));
      tmr_channel #(
         .CNT_W(CNT_W), .N_CMP(N_CMP), .PS_W(PS_W), .DATA_W(DATA_W), .KIND_W(KIND_W)
      ) u_ch (
         .clk(clk), .rst_n(rst_n),
         .wr_en(sel[g] && bus_we), .rd_en(sel[g] && !bus_we),
         .kind(kind_i[KIND_W-1:0]), .wdata(bus_wdata),
         .rdata(ch_rdata[g]), .irq(irq[g])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < N_CH; c++)
         if (rd_go && sel[c]) bus_rdata = ch_rdata[c];
   end

   p_one_channel_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
endmodule

// File: tb/tri_timer_test.sv
module tri_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  irq;
   int total = 0, bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   tri_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // register kinds, offset = 12*kind + 4*channel
   localparam int DIV = 0, CTL = 1, CNT = 2, LIM = 3, CM0 = 4, CM1 = 5, CM2 = 6;
   localparam int STS = 7, IEN = 8, EVC = 9, EVN = 10;

   function automatic logic [7:0] ad(input int kind, input int ch);
      return 8'(12 * kind + 4 * ch);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // all bus tasks start and end at a falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // start with ctl (stop clear), let exactly k clock edges count, then stop
   task automatic run(input int ch, input logic [31:0] ctl, input int k);
      wr(ad(CTL, ch), ctl & ~32'h1);
      idle(k - 1);
      wr(ad(CTL, ch), ctl | 32'h1);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int c = 0; c < 3; c++) begin
         rd(ad(CTL, c), d); chk("R1 ctrl reset", d, 32'h21);
         rd(ad(CNT, c), d); chk("R1 count reset", d, 32'h0);
         rd(ad(STS, c), d); chk("R1 status reset", d, 32'h0);
      end
      rd(ad(DIV, 0), d); chk("R1 divider reset", d, 32'h0);
      chk("R1 irq reset", {29'b0, irq}, 32'h0);
   endtask

   task automatic t_map;
      logic [31:0] d;
      wr(ad(LIM, 1), 32'h1234);
      wr(ad(LIM, 2), 32'h0055);
      rd(ad(LIM, 1), d); chk("R10 ch1 limit", d, 32'h1234);
      rd(ad(LIM, 2), d); chk("R10 ch2 limit", d, 32'h0055);
      rd(ad(LIM, 0), d); chk("R10 ch0 limit untouched", d, 32'h0);
      wr(ad(CNT, 0), 32'h77);
      rd(ad(CNT, 0), d); chk("R10 count read-only", d, 32'h0);
      wr(ad(EVC, 0), 32'hFF);
      rd(ad(EVC, 0), d); chk("R10 event control 3 bits", d, 32'h7);
      rd(ad(EVN, 0), d); chk("R10 event count reads 0", d, 32'h0);
      rd(8'h84, d); chk("R10 unmapped reads 0", d, 32'h0);
      rd(8'h25, d); chk("R10 unaligned reads 0", d, 32'h0);
   endtask

   task automatic t_free_up;
      logic [31:0] d;
      run(0, 32'h0, 10);
      rd(ad(CNT, 0), d); chk("R2 undivided count", d, 32'd10);
      idle(4);
      rd(ad(CNT, 0), d); chk("R3 stopped count holds", d, 32'd10);
      wr(ad(CTL, 0), 32'h11);
      rd(ad(CNT, 0), d); chk("R6 clear count", d, 32'h0);
      rd(ad(CTL, 0), d); chk("R6 clear bit reads 0", d, 32'h1);
   endtask

   task automatic t_limit_up;
      logic [31:0] d;
      wr(ad(LIM, 1), 32'd4);
      wr(ad(IEN, 1), 32'h01);
      wr(ad(CTL, 1), 32'h13);
      run(1, 32'h2, 7);                   // 1,2,3,4,0(wrap),1,2
      rd(ad(CNT, 1), d); chk("R4 limit wrap count", d, 32'd2);
      chk("R9 irq on enabled event", {31'b0, irq[1]}, 32'h1);
      rd(ad(STS, 1), d); chk("R4 limit wrap status", d, 32'h01);
      chk("R9 irq drops after read", {31'b0, irq[1]}, 32'h0);
      rd(ad(STS, 1), d); chk("R8 read clears status", d, 32'h0);
      wr(ad(STS, 1), 32'h3F);
      rd(ad(STS, 1), d); chk("R8 status write ignored", d, 32'h0);
      chk("R8 irq stays low after status write", {31'b0, irq[1]}, 32'h0);
   endtask

   task automatic t_down;
      logic [31:0] d;
      wr(ad(CTL, 2), 32'h11);
      run(2, 32'h4, 1);                   // 0 -> 0xFFFF
      rd(ad(CNT, 2), d); chk("R5 full-range reload", d, 32'hFFFF);
      rd(ad(STS, 2), d); chk("R4 overflow status", d, 32'h10);
      chk("R9 masked event keeps irq low", {31'b0, irq[2]}, 32'h0);
      run(2, 32'h4, 2);
      rd(ad(CNT, 2), d); chk("R5 decrement", d, 32'hFFFD);
      wr(ad(LIM, 2), 32'd4);
      wr(ad(CTL, 2), 32'h17);
      run(2, 32'h6, 3);                   // 4(wrap),3,2
      rd(ad(CNT, 2), d); chk("R5 limit reload", d, 32'd2);
      rd(ad(STS, 2), d); chk("R5 down wrap status", d, 32'h01);
   endtask

   task automatic t_compare;
      logic [31:0] d;
      wr(ad(LIM, 0), 32'd10);
      wr(ad(CM0, 0), 32'd3);
      wr(ad(CM1, 0), 32'd20);             // above the limit: never fires
      wr(ad(CM2, 0), 32'd10);
      wr(ad(CTL, 0), 32'h11);
      run(0, 32'hA, 5);                   // 1..5
      rd(ad(STS, 0), d); chk("R7 compare 0 hit", d, 32'h02);
      run(0, 32'hA, 6);                   // 6..10, 0
      rd(ad(STS, 0), d); chk("R7 compare 2 at limit plus wrap", d, 32'h09);
      rd(ad(CM0, 0), d); chk("R10 compare 0 readback", d, 32'd3);
      wr(ad(CTL, 0), 32'h11);
      run(0, 32'h2, 5);
      rd(ad(STS, 0), d); chk("R7 compare disabled", d, 32'h0);
   endtask

   task automatic t_prescale;
      logic [31:0] d;
      // N=1: one advance per 4 clocks, first one 4 clocks after the divider write
      wr(ad(DIV, 1), 32'h03);
      wr(ad(CTL, 1), 32'h11);
      run(1, 32'h0, 20);
      rd(ad(CNT, 1), d); chk("R2 divide by 4", d, 32'd5);
      rd(ad(DIV, 1), d); chk("R2 divider readback", d, 32'h03);
      // N=0: one advance per 2 clocks
      wr(ad(DIV, 1), 32'h01);
      wr(ad(CTL, 1), 32'h11);
      run(1, 32'h0, 10);
      rd(ad(CNT, 1), d); chk("R2 divide by 2", d, 32'd5);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_map();
      t_free_up();
      t_limit_up();
      t_down();
      t_compare();
      t_prescale();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule